// File: doc/BRIEF.md
# Two-Segment Gated Ternary Search Array

This block is a small ternary match array in which every entry is split into a short input segment and a longer state segment. Each stored bit is ternary: it has a value and a care flag, and a bit whose care flag is clear matches either search value. A search runs in two steps. First, only the input segments are compared against the input key. Then, one cycle later, the state segments are compared against the state key. Only the entries whose input segment matched take part in the second step. The state comparison of every other entry is suppressed.

Suppressing those comparisons leaves the result unchanged. An entry's final hit equals the result of comparing the whole word at once. A running counter totals the suppressed state comparisons, so that the gating can be observed from outside.

The controller is a three-state machine:
- `SRCH_IDLE` moves to `SRCH_INPUT` when a request is accepted. The keys are latched at that point.
- `SRCH_INPUT` moves to `SRCH_STATE` unconditionally. Here the input-segment results are registered.
- `SRCH_STATE` moves back to `SRCH_IDLE` unconditionally. Here the gated state results are registered into the hit vector, `done` is raised for one cycle and the skip counter is advanced.

Top module: `tsrch_gated_tcam`

## Requirements
- R1: After reset, `hit` is all zero, `done` and `busy` are low and `skip_cnt` is zero.
- R2: Each stored bit has a value and a care flag. A bit with care flag 0 matches key bit 0 and key bit 1. A bit with care flag 1 matches only when its value equals the key bit.
- R3: After a search, `hit[e]` is 1 exactly when every bit of entry e's input segment matches `key_in` and every bit of its state segment matches `key_st`. This holds for any storage order of the entries.
- R4: An entry whose input segment mismatches reports `hit[e]=0` and its state comparison is suppressed. `skip_cnt` grows by the number of such entries per search and wraps modulo 2^CNT_W.
- R5: A request is accepted only in `SRCH_IDLE`. `busy` is high for exactly the two cycles after acceptance. `done` is high for one cycle, in the cycle `busy` returns low, and in that same cycle the new `hit` and `skip_cnt` are visible.
- R6: `srch_req` while `busy` is high is ignored. It neither starts a search nor alters the running one's keys.
- R7: `hit` and `skip_cnt` hold their values between searches. A write does not change them.
- R8: With `wr_en` high, one clock edge writes both segments (values and care flags) of entry `wr_idx`. A search accepted afterwards uses the new contents. Reset leaves every entry as all-zero values with all care flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | $clog2(ENTRIES) | Entry written |
| wr_in_val | input | IN_W | Input-segment bit values |
| wr_in_care | input | IN_W | Input-segment care flags (0 = don't care) |
| wr_st_val | input | ST_W | State-segment bit values |
| wr_st_care | input | ST_W | State-segment care flags (0 = don't care) |
| srch_req | input | 1 | Search request |
| key_in | input | IN_W | Input key |
| key_st | input | ST_W | State key |
| hit | output | ENTRIES | Final per-entry match |
| done | output | 1 | One-cycle pulse: results valid |
| busy | output | 1 | Search in progress |
| skip_cnt | output | CNT_W | Running total of suppressed state comparisons |

## Verification
The bench builds the array with four entries, a 2-bit input segment and a 3-bit state segment. At that size every combination of input key and state key (32 pairs) can be swept against each of several stored tables. Each table is generated arithmetically and mixes care and don't-care bits. The sweep therefore covers every pattern of entries gated and not gated, and every ternary bit case. The expected hits and skip totals come from a direct whole-word comparison in the bench. Requests raised mid-search and writes between searches are added, to show that the latched keys and held results are undisturbed.

// File: rtl/tsrch_pkg.sv
package tsrch_pkg;
    typedef enum logic [1:0] {
        SRCH_IDLE  = 2'd0,
        SRCH_INPUT = 2'd1,
        SRCH_STATE = 2'd2
    } srch_state_t;
endpackage

// File: rtl/tsrch_store.sv
// Entry storage: both segments of every entry, written one entry per edge.
module tsrch_store #(
    parameter int ENTRIES = 8,
    parameter int IN_W    = 4,
    parameter int ST_W    = 12,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [IN_W-1:0]                wr_in_val,
    input  logic [IN_W-1:0]                wr_in_care,
    input  logic [ST_W-1:0]                wr_st_val,
    input  logic [ST_W-1:0]                wr_st_care,
    output logic [ENTRIES-1:0][IN_W-1:0]   in_val,
    output logic [ENTRIES-1:0][IN_W-1:0]   in_care,
    output logic [ENTRIES-1:0][ST_W-1:0]   st_val,
    output logic [ENTRIES-1:0][ST_W-1:0]   st_care
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                in_val[e]  <= '0;
                in_care[e] <= '1;
                st_val[e]  <= '0;
                st_care[e] <= '1;
            end else if (wr_en && (int'(wr_idx) == e)) begin
                in_val[e]  <= wr_in_val;
                in_care[e] <= wr_in_care;
                st_val[e]  <= wr_st_val;
                st_care[e] <= wr_st_care;
            end
        end
    end
endmodule

// File: rtl/tsrch_seg_cmp.sv
// Per-entry ternary compare of one segment, gated by a per-entry enable.
module tsrch_seg_cmp #(
    parameter int ENTRIES = 8,
    parameter int W       = 4
) (
    input  logic [ENTRIES-1:0][W-1:0] val,
    input  logic [ENTRIES-1:0][W-1:0] care,
    input  logic [W-1:0]              key,
    input  logic [ENTRIES-1:0]        en,
    output logic [ENTRIES-1:0]        match
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic [W-1:0] diff;
        assign diff     = (val[e] ^ key) & care[e];
        assign match[e] = en[e] & (diff == '0);
    end
endmodule

// File: rtl/tsrch_gated_tcam.sv
module tsrch_gated_tcam
    import tsrch_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IN_W    = 4,
    parameter int ST_W    = 12,
    parameter int CNT_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [$clog2(ENTRIES)-1:0]   wr_idx,
    input  logic [IN_W-1:0]              wr_in_val,
    input  logic [IN_W-1:0]              wr_in_care,
    input  logic [ST_W-1:0]              wr_st_val,
    input  logic [ST_W-1:0]              wr_st_care,
    input  logic                         srch_req,
    input  logic [IN_W-1:0]              key_in,
    input  logic [ST_W-1:0]              key_st,
    output logic [ENTRIES-1:0]           hit,
    output logic                         done,
    output logic                         busy,
    output logic [CNT_W-1:0]             skip_cnt
);
    logic [ENTRIES-1:0][IN_W-1:0] s_in_val, s_in_care;
    logic [ENTRIES-1:0][ST_W-1:0] s_st_val, s_st_care;
    logic [IN_W-1:0]              key_in_q;
    logic [ST_W-1:0]              key_st_q;
    logic [ENTRIES-1:0]           in_match, in_hit_q, st_match;
    logic [CNT_W-1:0]             skip_add;
    srch_state_t                  state_q, state_d;

    tsrch_store #(.ENTRIES(ENTRIES), .IN_W(IN_W), .ST_W(ST_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_in_val(wr_in_val), .wr_in_care(wr_in_care),
        .wr_st_val(wr_st_val), .wr_st_care(wr_st_care),
        .in_val(s_in_val), .in_care(s_in_care),
        .st_val(s_st_val), .st_care(s_st_care)
    );

    // Step one: every entry's input segment is compared.
    tsrch_seg_cmp #(.ENTRIES(ENTRIES), .W(IN_W)) u_in_cmp (
        .val(s_in_val), .care(s_in_care), .key(key_in_q),
        .en({ENTRIES{1'b1}}), .match(in_match)
    );

    // Step two: only entries whose input segment matched are evaluated.
    tsrch_seg_cmp #(.ENTRIES(ENTRIES), .W(ST_W)) u_st_cmp (
        .val(s_st_val), .care(s_st_care), .key(key_st_q),
        .en(in_hit_q), .match(st_match)
    );

    always_comb begin
        skip_add = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            skip_add = skip_add + CNT_W'(!in_hit_q[e]);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SRCH_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRCH_IDLE:  if (srch_req) state_d = SRCH_INPUT;
            SRCH_INPUT: state_d = SRCH_STATE;
            SRCH_STATE: state_d = SRCH_IDLE;
            default:    state_d = SRCH_IDLE;
        endcase
    end

    assign busy = (state_q != SRCH_IDLE);

    // Outputs and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            key_in_q <= '0;
            key_st_q <= '0;
            in_hit_q <= '0;
            hit      <= '0;
            done     <= 1'b0;
            skip_cnt <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                SRCH_IDLE: begin
                    if (srch_req) begin
                        key_in_q <= key_in;
                        key_st_q <= key_st;
                    end
                end
                SRCH_INPUT: in_hit_q <= in_match;
                SRCH_STATE: begin
                    hit      <= st_match;
                    done     <= 1'b1;
                    skip_cnt <= skip_cnt + skip_add;
                end
                default: ;
            endcase
        end
    end

    // R3 / R4: a reported hit always comes from an entry whose input segment matched
    assert_hit_gated_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> ((hit & ~in_hit_q) == '0));

    // R5: an accepted request makes the block busy on the next cycle
    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (srch_req && !busy) |=> busy);

    // R5: done follows exactly two busy cycles and is a single pulse
    assert_done_after_two_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy, 1) && $past(busy, 2)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: results only move when a search completes
    assert_hit_held_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(hit) |-> done);

    assert_skip_held_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(skip_cnt) |-> done);
endmodule

// File: tb/tb_tsrch_gated_tcam.sv
module tb_tsrch_gated_tcam;
    localparam int N  = 4;
    localparam int IW = 2;
    localparam int SW = 3;
    localparam int CW = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic            wr_en;
    logic [1:0]      wr_idx;
    logic [IW-1:0]   wr_in_val, wr_in_care;
    logic [SW-1:0]   wr_st_val, wr_st_care;
    logic            srch_req;
    logic [IW-1:0]   key_in;
    logic [SW-1:0]   key_st;
    logic [N-1:0]    hit;
    logic            done, busy;
    logic [CW-1:0]   skip_cnt;

    tsrch_gated_tcam #(.ENTRIES(N), .IN_W(IW), .ST_W(SW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_in_val(wr_in_val), .wr_in_care(wr_in_care),
        .wr_st_val(wr_st_val), .wr_st_care(wr_st_care),
        .srch_req(srch_req), .key_in(key_in), .key_st(key_st),
        .hit(hit), .done(done), .busy(busy), .skip_cnt(skip_cnt)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int unsigned lcg = 32'h1234_5678;

    logic [IW-1:0] m_iv [N];
    logic [IW-1:0] m_ic [N];
    logic [SW-1:0] m_sv [N];
    logic [SW-1:0] m_sc [N];
    logic [CW-1:0] exp_skip = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return (lcg >> 16) & 32'h7fff;
    endfunction

    // Ternary bit rule, written bit by bit (R2)
    function automatic bit tmatch(input int val, input int care, input int key, input int w);
        for (int b = 0; b < w; b++) begin
            if (((care >> b) & 1) == 1 && ((val >> b) & 1) != ((key >> b) & 1)) return 0;
        end
        return 1;
    endfunction

    task automatic write_entry(input int e, input int iv, input int ic, input int sv, input int sc);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(e);
        wr_in_val = IW'(iv); wr_in_care = IW'(ic);
        wr_st_val = SW'(sv); wr_st_care = SW'(sc);
        @(negedge clk);
        wr_en = 1'b0;
        m_iv[e] = IW'(iv); m_ic[e] = IW'(ic);
        m_sv[e] = SW'(sv); m_sc[e] = SW'(sc);
    endtask

    task automatic do_search(input int ki, input int ks, input bit intrude);
        logic [N-1:0] exp_hit;
        int skipped;
        exp_hit = '0;
        skipped = 0;
        for (int e = 0; e < N; e++) begin
            if (tmatch(int'(m_iv[e]), int'(m_ic[e]), ki, IW)) begin
                exp_hit[e] = tmatch(int'(m_sv[e]), int'(m_sc[e]), ks, SW);
            end else begin
                skipped++;
            end
        end
        exp_skip = exp_skip + CW'(skipped);

        @(negedge clk);
        srch_req = 1'b1; key_in = IW'(ki); key_st = SW'(ks);
        @(negedge clk);
        // R6: a request with other keys while busy must be ignored
        srch_req = intrude; key_in = ~IW'(ki); key_st = ~SW'(ks);
        chk(busy && !done, "R5", "first busy cycle", int'({busy, done}), 2);
        @(negedge clk);
        srch_req = 1'b0;
        chk(busy && !done, "R5", "second busy cycle", int'({busy, done}), 2);
        @(negedge clk);
        chk(done && !busy, "R5", "done cycle", int'({busy, done}), 1);
        chk(hit == exp_hit, "R2 R3", "hit vector", int'(hit), int'(exp_hit));
        chk(skip_cnt == exp_skip, "R4", "skip count", int'(skip_cnt), int'(exp_skip));
        @(negedge clk);
        chk(!done && !busy, "R6", "no extra search", int'({busy, done}), 0);
        chk(hit == exp_hit, "R7", "hit held", int'(hit), int'(exp_hit));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [N-1:0] held_hit;
        logic [CW-1:0] held_skip;
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0;
        wr_in_val = '0; wr_in_care = '0; wr_st_val = '0; wr_st_care = '0;
        srch_req = 1'b0; key_in = '0; key_st = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(hit == '0, "R1", "hit after reset", int'(hit), 0);
        chk(!done && !busy, "R1", "done/busy after reset", int'({busy, done}), 0);
        chk(skip_cnt == '0, "R1", "skip after reset", int'(skip_cnt), 0);

        // R8: reset contents are all-zero values with every care flag set
        for (int e = 0; e < N; e++) begin
            m_iv[e] = '0; m_ic[e] = '1; m_sv[e] = '0; m_sc[e] = '1;
        end
        do_search(0, 0, 1'b0);
        do_search(1, 0, 1'b0);

        // Sweeps over several arithmetically generated tables
        for (int t = 0; t < 4; t++) begin
            for (int e = 0; e < N; e++) begin
                if (t == 0) write_entry(e, e, 3, e, 7 - e);  // distinct input keys, mixed care
                else write_entry(e, int'(rnd()), int'(rnd()), int'(rnd()), int'(rnd()));
            end
            for (int ki = 0; ki < (1 << IW); ki++) begin
                for (int ks = 0; ks < (1 << SW); ks++) begin
                    do_search(ki, ks, ((ki + ks) % 3) == 0);
                end
            end
        end

        // All entries fully don't-care: nothing skipped, all hit (R2 R4)
        for (int e = 0; e < N; e++) write_entry(e, 0, 0, 0, 0);
        do_search(2, 5, 1'b1);

        // R7: a write does not disturb held results; R8: next search uses it
        held_hit = hit;
        held_skip = skip_cnt;
        write_entry(1, 3, 3, 6, 7);
        repeat (2) @(negedge clk);
        chk(hit == held_hit, "R7", "hit after write", int'(hit), int'(held_hit));
        chk(skip_cnt == held_skip, "R7", "skip after write", int'(skip_cnt), int'(held_skip));
        chk(!done, "R7", "no done from write", int'(done), 0);
        do_search(3, 6, 1'b0);
        chk(hit == 4'b1111, "R8", "rewritten entry used", int'(hit), 15);
        do_search(0, 6, 1'b0);
        chk(hit == 4'b1101, "R8", "rewritten entry gated", int'(hit), 13);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule